// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the 8-bit status byte of a small serial NOR flash and decides whether each decoded command may change the memory or the protection settings. It receives one-cycle command strobes from the command decoder. These are write-enable, write-disable, status write, page program, sector erase, block erase and chip erase. It also receives a completion pulse from the array sequencer, the level of the active-low write-protect pin and the target address of the current command.

For every command it returns a one-cycle accept or reject pulse. It also drives the status byte that a status read shifts out. The four protection bits behave like non-volatile cells. A dedicated power-up reset loads them from a preset value, and the normal reset leaves them untouched. The serial shifter, the array timing and the real non-volatile storage live elsewhere.

All command effects are registered. A strobe sampled on one rising edge shows its result on `cmd_accept`, `cmd_reject` and `status` right after that edge. No data stream passes through this block, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `flash_sts_ctrl`

## Requirements
- R1: After either reset, BUSY (status bit 0) and the write-enable latch WEL (status bit 1) read 0. The status byte is laid out as bit 7 lock, bit 5 bottom-select, bits 3:2 size code (bit 3 high), bits 4 and 6 zero, bit 1 WEL and bit 0 BUSY.
- R2: A status write, page program, sector erase, block erase or chip erase issued while WEL is 0 is rejected. BUSY stays 0 and no bit of the status byte changes.
- R3: Write-disable clears WEL at once. A completion pulse received while BUSY is 1 clears both BUSY and WEL.
- R4: While `por_n` is low, the protection bits load from `prot_preset` ({lock, bottom, size[1:0]}). A `rst_n` pulse leaves them unchanged.
- R5: Status bits 4 and 6 always read 0, whatever value a status write carries.
- R6: An accepted status write copies data bits 7, 5, 3 and 2 into lock, bottom-select and size. When lock is 1 and `wp_n` is low, a status write is rejected and the status byte, WEL included, stays as it was.
- R7: The size code selects the protected area. 00 protects nothing, 01 a quarter and 10 a half of the address space, and 11 the whole of it. For 01 and 10, bottom-select 1 places the area at the lowest addresses and 0 at the highest. A program or erase whose address falls inside the area is rejected.
- R8: A chip erase is accepted only when bottom-select and both size bits are 0. Otherwise it is rejected.
- R9: While BUSY is 1, every command strobe is ignored. No accept or reject pulse is produced and the status byte is unchanged.
- R10: A command rejected for protection leaves BUSY at 0 and WEL at its previous value.
- R11: Write-enable sets WEL when BUSY is 0. An accepted status write, program or erase raises BUSY. Each command that is not ignored yields exactly one of `cmd_accept` or `cmd_reject` for one cycle. `wr_permit` is 1 exactly when WEL is 1 and BUSY is 0.
- R12: If several strobes arrive in one cycle, only one is acted on. The order of precedence is chip erase, block erase, sector erase, page program, status write, write-disable, write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-up reset; loads protection preset |
| rst_n | input | 1 | Active-low normal reset; clears BUSY and WEL only |
| prot_preset | input | 4 | Power-up value {lock, bottom, size[1:0]} |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| wrsr_data | input | 8 | Byte carried by a status write |
| addr | input | ADDR_W | Target address of program or erase |
| op_done | input | 1 | Completion pulse from the array sequencer |
| status | output | 8 | Status byte |
| wr_permit | output | 1 | WEL set and device idle |
| cmd_accept | output | 1 | One-cycle pulse: command accepted |
| cmd_reject | output | 1 | One-cycle pulse: command refused |

## Verification
The bench uses the default `ADDR_W` of 18, which gives a 256 KB space. Its quarter and half boundaries fall at 0x10000, 0x20000 and 0x30000. Addresses one below and at each boundary are driven to exercise both edges of every protected area, in both top and bottom placement. The preset and the status-write path reach every lock and pin combination.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_WRSR, OP_PP, OP_SE, OP_BE, OP_CE
  } op_e;

  typedef struct packed {
    logic       lock;
    logic       bottom;
    logic [1:0] size;
  } prot_t;

  localparam int S_BUSY = 0;
  localparam int S_WEL  = 1;
  localparam int S_SZ0  = 2;
  localparam int S_SZ1  = 3;
  localparam int S_BOT  = 5;
  localparam int S_LOCK = 7;
endpackage

// File: rtl/flash_cmd_pick.sv
module flash_cmd_pick
  import flash_sts_pkg::*;
(
  input  logic wren,
  input  logic wrdi,
  input  logic wrsr,
  input  logic pp,
  input  logic se,
  input  logic be,
  input  logic ce,
  output op_e  op
);
  always_comb begin
    if (ce)        op = OP_CE;
    else if (be)   op = OP_BE;
    else if (se)   op = OP_SE;
    else if (pp)   op = OP_PP;
    else if (wrsr) op = OP_WRSR;
    else if (wrdi) op = OP_WRDI;
    else if (wren) op = OP_WREN;
    else           op = OP_NONE;
  end
endmodule

// File: rtl/flash_prot_store.sv
module flash_prot_store
  import flash_sts_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  prot_t preset,
  input  logic  we,
  input  prot_t wdata,
  output prot_t q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  q <= preset;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/flash_prot_map.sv
module flash_prot_map
  import flash_sts_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  prot_t             prot,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              any_set
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] quad;
  assign quad    = addr[TOP -: 2];
  assign any_set = prot.bottom | (|prot.size);

  always_comb begin
    unique case (prot.size)
      2'b00: hit = 1'b0;
      2'b01: hit = prot.bottom ? (quad == 2'b00) : (quad == 2'b11);
      2'b10: hit = prot.bottom ? !quad[1] : quad[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_sts_ctrl.sv
module flash_sts_ctrl
  import flash_sts_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [3:0]        prot_preset,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [7:0]        wrsr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              op_done,
  output logic [7:0]        status,
  output logic              wr_permit,
  output logic              cmd_accept,
  output logic              cmd_reject
);
  op_e   op;
  prot_t prot, prot_new;
  logic  hit, any_set, locked;
  logic  busy, wel, busy_d, wel_d, acc_d, rej_d, prot_we;
  logic  rst_all_n;

  assign rst_all_n = rst_n & por_n;
  assign locked    = prot.lock & ~wp_n;
  assign prot_new  = '{lock:   wrsr_data[S_LOCK],
                       bottom: wrsr_data[S_BOT],
                       size:   {wrsr_data[S_SZ1], wrsr_data[S_SZ0]}};

  flash_cmd_pick u_pick (
    .wren(cmd_wren), .wrdi(cmd_wrdi), .wrsr(cmd_wrsr), .pp(cmd_pp),
    .se(cmd_se), .be(cmd_be), .ce(cmd_ce), .op(op)
  );

  flash_prot_store u_store (
    .clk(clk), .por_n(por_n), .preset(prot_t'(prot_preset)),
    .we(prot_we), .wdata(prot_new), .q(prot)
  );

  flash_prot_map #(.ADDR_W(ADDR_W)) u_map (
    .prot(prot), .addr(addr), .hit(hit), .any_set(any_set)
  );

  always_comb begin
    busy_d  = busy;
    wel_d   = wel;
    acc_d   = 1'b0;
    rej_d   = 1'b0;
    prot_we = 1'b0;
    if (busy) begin
      if (op_done) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
      end
    end else begin
      unique case (op)
        OP_WREN: begin wel_d = 1'b1; acc_d = 1'b1; end
        OP_WRDI: begin wel_d = 1'b0; acc_d = 1'b1; end
        OP_WRSR: begin
          if (!wel || locked) rej_d = 1'b1;
          else begin
            acc_d   = 1'b1;
            busy_d  = 1'b1;
            prot_we = rst_n;
          end
        end
        OP_PP, OP_SE, OP_BE: begin
          if (!wel || hit) rej_d = 1'b1;
          else begin acc_d = 1'b1; busy_d = 1'b1; end
        end
        OP_CE: begin
          if (!wel || any_set) rej_d = 1'b1;
          else begin acc_d = 1'b1; busy_d = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      busy       <= 1'b0;
      wel        <= 1'b0;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      busy       <= busy_d;
      wel        <= wel_d;
      cmd_accept <= acc_d;
      cmd_reject <= rej_d;
    end
  end

  always_comb begin
    status         = '0;
    status[S_BUSY] = busy;
    status[S_WEL]  = wel;
    status[S_SZ0]  = prot.size[0];
    status[S_SZ1]  = prot.size[1];
    status[S_BOT]  = prot.bottom;
    status[S_LOCK] = prot.lock;
  end

  assign wr_permit = wel & ~busy;
endmodule

// File: rtl/flash_sts_chk.sv
module flash_sts_chk #(
  parameter int ADDR_W = 18
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       wp_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic       cmd_pp,
  input logic       cmd_se,
  input logic       cmd_be,
  input logic       cmd_ce,
  input logic       op_done,
  input logic [7:0] status,
  input logic       cmd_accept,
  input logic       cmd_reject
);
  logic any_cmd;
  assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(cmd_accept && cmd_reject)); // R11

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    status[4] == 1'b0 && status[6] == 1'b0); // R5

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[0] && any_cmd) |=> (!cmd_accept && !cmd_reject)); // R9

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[0] && op_done) |=> (!status[0] && !status[1])); // R3

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(status[0]) |-> $past(status[1])); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!wp_n && status[7]) |=> $stable({status[7], status[5], status[3:2]})); // R6

  AST_CE_GUARD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cmd_ce && !status[0] && (status[5] || status[3] || status[2])) |=> cmd_reject); // R8
endmodule

bind flash_sts_ctrl flash_sts_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
  .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
  .op_done(op_done), .status(status),
  .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
);

// File: tb/flash_sts_ctrl_tb.sv
module flash_sts_ctrl_tb;
  import flash_sts_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          por_n = 1'b0, rst_n = 1'b0, wp_n = 1'b1, op_done = 1'b0;
  logic [3:0]    prot_preset = 4'h0;
  logic          s_wren = 0, s_wrdi = 0, s_wrsr = 0, s_pp = 0, s_se = 0, s_be = 0, s_ce = 0;
  logic [7:0]    wdata = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          wr_permit, cmd_accept, cmd_reject;
  int            n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sts_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .prot_preset(prot_preset), .wp_n(wp_n),
    .cmd_wren(s_wren), .cmd_wrdi(s_wrdi), .cmd_wrsr(s_wrsr), .cmd_pp(s_pp),
    .cmd_se(s_se), .cmd_be(s_be), .cmd_ce(s_ce), .wrsr_data(wdata), .addr(addr),
    .op_done(op_done), .status(status), .wr_permit(wr_permit),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    {s_wren, s_wrdi, s_wrsr, s_pp, s_se, s_be, s_ce} = '0;
  endtask

  // Drive one strobe for one edge; on return the registered outputs are visible.
  task automatic issue(input op_e op, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    case (op)
      OP_WREN: s_wren = 1'b1;
      OP_WRDI: s_wrdi = 1'b1;
      OP_WRSR: s_wrsr = 1'b1;
      OP_PP:   s_pp   = 1'b1;
      OP_SE:   s_se   = 1'b1;
      OP_BE:   s_be   = 1'b1;
      OP_CE:   s_ce   = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic set_prot(input logic [7:0] d);
    issue(OP_WREN, '0, 8'h00);
    issue(OP_WRSR, '0, d);
    done_pulse();
  endtask

  task automatic t_reset();
    check("R1 status after power-up", status, 8'h00);
    check("R11 wr_permit after reset", {7'd0, wr_permit}, 8'h00);
  endtask

  task automatic t_wel_required();
    issue(OP_PP, '0, 8'h00);
    check("R2 program without WEL rejected", {6'd0, cmd_accept, cmd_reject}, 8'h01);
    check("R2 status unchanged", status, 8'h00);
    issue(OP_WRSR, '0, 8'h0C);
    check("R2 status write without WEL", status, 8'h00);
  endtask

  task automatic t_wren_wrdi();
    issue(OP_WREN, '0, 8'h00);
    check("R11 write-enable sets WEL", status, 8'h02);
    check("R11 wr_permit", {7'd0, wr_permit}, 8'h01);
    issue(OP_WRDI, '0, 8'h00);
    check("R3 write-disable clears WEL", status, 8'h00);
  endtask

  task automatic t_busy();
    issue(OP_WREN, '0, 8'h00);
    issue(OP_SE, '0, 8'h00);
    check("R11 sector erase accepted, BUSY up", {cmd_accept, cmd_reject, status[5:0]}, 8'h83);
    issue(OP_WRDI, '0, 8'h00);
    check("R9 command ignored while busy", {cmd_accept, cmd_reject, status[5:0]}, 8'h03);
    issue(OP_CE, '0, 8'h00);
    check("R9 chip erase ignored while busy", {cmd_accept, cmd_reject, status[5:0]}, 8'h03);
    done_pulse();
    check("R3 completion clears BUSY and WEL", status, 8'h00);
    done_pulse();
    check("R3 stray completion harmless", status, 8'h00);
  endtask

  task automatic t_wrsr();
    issue(OP_WREN, '0, 8'h00);
    issue(OP_WRSR, '0, 8'hFF);
    check("R5 reserved bits zero after all-ones write", status, 8'hAF);
    done_pulse();
    check("R6 protection bits written", status, 8'hAC);
    wp_n = 1'b0;
    issue(OP_WREN, '0, 8'h00);
    issue(OP_WRSR, '0, 8'h00);
    check("R6 locked status write rejected", {6'd0, cmd_accept, cmd_reject}, 8'h01);
    check("R6 status kept when locked", status, 8'hAE);
    wp_n = 1'b1;
    issue(OP_WRSR, '0, 8'h00);
    check("R6 status write with pin high", status, 8'h03);
    done_pulse();
    check("R6 protection cleared", status, 8'h00);
  endtask

  task automatic prog_check(input string req, input logic [AW-1:0] a, input logic expect_ok,
                            input logic [7:0] prot_bits);
    issue(OP_WREN, '0, 8'h00);
    issue(OP_PP, a, 8'h00);
    check(req, {cmd_accept, cmd_reject, status[5:0]},
          expect_ok ? {2'b10, prot_bits[5:2], 2'b11} : {2'b01, prot_bits[5:2], 2'b10});
    if (expect_ok) done_pulse();
    else issue(OP_WRDI, '0, 8'h00);
  endtask

  task automatic t_prot_map();
    set_prot(8'h00);
    prog_check("R7 nothing protected", 18'h3FFFF, 1'b1, 8'h00);
    set_prot(8'h04);
    prog_check("R7 top quarter last addr", 18'h3FFFF, 1'b0, 8'h04);
    prog_check("R7 top quarter first addr", 18'h30000, 1'b0, 8'h04);
    prog_check("R7 below top quarter", 18'h2FFFF, 1'b1, 8'h04);
    set_prot(8'h24);
    prog_check("R7 bottom quarter edge", 18'h0FFFF, 1'b0, 8'h24);
    prog_check("R7 above bottom quarter", 18'h10000, 1'b1, 8'h24);
    set_prot(8'h08);
    prog_check("R7 top half edge", 18'h20000, 1'b0, 8'h08);
    prog_check("R7 below top half", 18'h1FFFF, 1'b1, 8'h08);
    set_prot(8'h28);
    prog_check("R7 bottom half edge", 18'h1FFFF, 1'b0, 8'h28);
    prog_check("R10 above bottom half", 18'h20000, 1'b1, 8'h28);
    set_prot(8'h0C);
    prog_check("R10 whole array protected", 18'h00000, 1'b0, 8'h0C);
  endtask

  task automatic t_chip_erase();
    set_prot(8'h20);
    issue(OP_WREN, '0, 8'h00);
    issue(OP_CE, '0, 8'h00);
    check("R8 chip erase refused with bottom-select set", {cmd_accept, cmd_reject, status[5:0]}, 8'h62);
    set_prot(8'h00);
    issue(OP_WREN, '0, 8'h00);
    issue(OP_CE, '0, 8'h00);
    check("R8 chip erase accepted with no protection", {cmd_accept, cmd_reject, status[5:0]}, 8'h83);
    done_pulse();
  endtask

  task automatic t_priority();
    set_prot(8'h04);
    issue(OP_WREN, '0, 8'h00);
    @(negedge clk); addr = '0; s_ce = 1'b1; s_pp = 1'b1;
    @(negedge clk); clear_strobes();
    check("R12 chip erase wins over program", {6'd0, cmd_accept, cmd_reject}, 8'h01);
    @(negedge clk); s_wren = 1'b1; s_wrdi = 1'b1;
    @(negedge clk); clear_strobes();
    check("R12 write-disable wins over write-enable", status, 8'h04);
  endtask

  task automatic t_resets();
    set_prot(8'h8C);
    issue(OP_WREN, '0, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R4 normal reset keeps protection", status, 8'h8C);
    prot_preset = 4'b0101;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check("R4 power-up loads preset", status, 8'h24);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel_required();
    t_wren_wrdi();
    t_busy();
    t_wrsr();
    t_prot_map();
    t_chip_erase();
    t_priority();
    t_resets();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule